// File: doc/BRIEF.md
# Priority Interrupt Chain Node

This block is one link in a serial chain that ranks interrupt sources by position. Each node receives a chain enable from its higher-priority neighbour and passes a chain enable on to its lower-priority neighbour. A local request pulse makes the node pending. When the processor acknowledges an interrupt, the node checks whether it is the highest-priority requester. If it is, it places its programmable vector on the data bus and moves to an under-service state. In that state it holds the chain enable low for every node below it until an end-of-service pulse releases it.

An acknowledge is recognised when the first-machine-cycle strobe and the I/O strobe are both low in the same clock cycle. No separate acknowledge pin is used. The state can change only on a clock edge. A controller with four states holds the node's condition:

- `ST_IDLE`: no request and no service.
- `ST_PEND`: a request is waiting.
- `ST_SERV`: the node is under service.
- `ST_SERV_PEND`: the node is under service and a new request has been stored.

The transitions are:

- **IDLE→PEND**: a request pulse arrives.
- **PEND→SERV**: a grant.
- **PEND→SERV_PEND**: a grant together with a fresh request pulse.
- **SERV→SERV_PEND**: a request pulse arrives during service.
- **SERV→IDLE**: a release.
- **SERV→PEND**: a release together with a request pulse.
- **SERV_PEND→PEND**: a release.

A grant is an acknowledge while the node is pending and its enable in is high. A release is an end-of-service pulse while its enable in is high. Synchronous reset returns the node to IDLE from any state.

Top module: `irq_chain_node`

## Requirements
- R1: After a cycle with `rst` high, the node is idle: `irq_n` is 1, `bus_oe` is 0, `bus_out` is 0, and `chain_en_out` equals `chain_en_in`.
- R2: A one-cycle `req_pulse` in the idle state makes the node pending from the next clock edge.
- R3: `irq_n` is 0 exactly when the node is pending, not under service, and `chain_en_in` is 1. While `chain_en_in` is 0 a pending request is kept but not signalled.
- R4: An acknowledge is `fetch_strobe_n`=0 and `io_strobe_n`=0 in the same cycle. While the node is pending, not under service, with `chain_en_in`=1, an acknowledge sets `bus_oe`=1 and `bus_out`=`vector` in that same cycle. At all other times `bus_oe`=0 and `bus_out`=0.
- R5: An acknowledge while pending with `chain_en_in`=0 drives nothing, and the request stays pending.
- R6: After a grant edge the node is under service: `irq_n`=1 and `chain_en_out`=0.
- R7: `chain_en_out` = `chain_en_in` AND not under service AND NOT (pending AND acknowledge).
- R8: `done_pulse` releases service only when `chain_en_in`=1. Otherwise it has no effect.
- R9: A `req_pulse` during service is remembered. After release the node is pending again.
- R10: Extra request pulses while already pending merge into one request, so one grant clears them all.
- R11: Only one strobe low is not an acknowledge, and it does not drive the bus or change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_en_in | input | 1 | Enable from higher-priority neighbour |
| chain_en_out | output | 1 | Enable to lower-priority neighbour |
| req_pulse | input | 1 | Local request, one-cycle pulse |
| fetch_strobe_n | input | 1 | First-machine-cycle strobe, active low |
| io_strobe_n | input | 1 | I/O request strobe, active low |
| done_pulse | input | 1 | End-of-service pulse |
| vector | input | VEC_W | Programmable interrupt vector |
| irq_n | output | 1 | Interrupt request, active low |
| bus_out | output | VEC_W | Vector onto data bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The hardest condition to reach is ST_SERV_PEND followed by a release. It needs four things in order:

1. a request,
2. a grant with enable in high,
3. a second request during service,
4. an end-of-service pulse while enable in is high.

A second hard case is a release attempt with enable in low, after which enable in must rise again. Directed sequences build these orders explicitly. Several thousand biased random cycles, with requests, strobes and release pulses at moderate rates and enable in mostly high, reach them again in many interleavings.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PEND      = 2'd1,
        ST_SERV      = 2'd2,
        ST_SERV_PEND = 2'd3
    } node_state_t;
endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode (
    input  logic fetch_strobe_n,
    input  logic io_strobe_n,
    output logic ack
);
    // both strobes low together mark an acknowledge cycle
    assign ack = ~fetch_strobe_n & ~io_strobe_n;
endmodule

// File: rtl/irq_node_fsm.sv
module irq_node_fsm
    import irq_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_pulse,
    input  logic        grant,
    input  logic        done_pulse,
    input  logic        chain_en_in,
    output node_state_t state
);
    node_state_t state_nx;
    logic        release_ok;

    assign release_ok = done_pulse & chain_en_in;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_pulse) state_nx = ST_PEND;
            ST_PEND:      if (grant) state_nx = req_pulse ? ST_SERV_PEND : ST_SERV;
            ST_SERV: begin
                if (release_ok)     state_nx = req_pulse ? ST_PEND : ST_IDLE;
                else if (req_pulse) state_nx = ST_SERV_PEND;
            end
            ST_SERV_PEND: if (release_ok) state_nx = ST_PEND;
            default:      state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_node_drive.sv
module irq_node_drive
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  node_state_t      state,
    input  logic             ack,
    input  logic             chain_en_in,
    input  logic [VEC_W-1:0] vector,
    output logic             irq_n,
    output logic             chain_en_out,
    output logic             bus_oe,
    output logic [VEC_W-1:0] bus_out,
    output logic             grant
);
    always_comb begin
        irq_n        = 1'b1;
        chain_en_out = 1'b0;
        bus_oe       = 1'b0;
        unique case (state)
            ST_IDLE: chain_en_out = chain_en_in;
            ST_PEND: begin
                irq_n        = ~chain_en_in;
                bus_oe       = ack & chain_en_in;
                // a pending node claims the chain while an acknowledge resolves
                chain_en_out = chain_en_in & ~ack;
            end
            ST_SERV, ST_SERV_PEND: chain_en_out = 1'b0;
            default: chain_en_out = 1'b0;
        endcase
    end

    assign bus_out = bus_oe ? vector : '0;
    assign grant   = bus_oe;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chain_en_in,
    output logic             chain_en_out,
    input  logic             req_pulse,
    input  logic             fetch_strobe_n,
    input  logic             io_strobe_n,
    input  logic             done_pulse,
    input  logic [VEC_W-1:0] vector,
    output logic             irq_n,
    output logic [VEC_W-1:0] bus_out,
    output logic             bus_oe
);
    logic        ack;
    logic        grant;
    node_state_t state;

    irq_ack_decode u_ack (
        .fetch_strobe_n (fetch_strobe_n),
        .io_strobe_n    (io_strobe_n),
        .ack            (ack)
    );

    irq_node_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_pulse   (req_pulse),
        .grant       (grant),
        .done_pulse  (done_pulse),
        .chain_en_in (chain_en_in),
        .state       (state)
    );

    irq_node_drive #(.VEC_W(VEC_W)) u_drive (
        .state        (state),
        .ack          (ack),
        .chain_en_in  (chain_en_in),
        .vector       (vector),
        .irq_n        (irq_n),
        .chain_en_out (chain_en_out),
        .bus_oe       (bus_oe),
        .bus_out      (bus_out),
        .grant        (grant)
    );
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             chain_en_in,
    input logic             chain_en_out,
    input logic             fetch_strobe_n,
    input logic             io_strobe_n,
    input logic [VEC_W-1:0] vector,
    input logic             irq_n,
    input logic [VEC_W-1:0] bus_out,
    input logic             bus_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && !bus_oe));

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> chain_en_in);

    assert_drive_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!fetch_strobe_n && !io_strobe_n && chain_en_in && bus_out == vector));

    assert_bus_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));

    assert_grant_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |=> (irq_n && !chain_en_out));

    assert_out_needs_in_R7: assert property (@(posedge clk) disable iff (rst)
        chain_en_out |-> chain_en_in);

    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        (fetch_strobe_n || io_strobe_n) |-> !bus_oe);
endmodule

bind irq_chain_node irq_chain_node_chk #(.VEC_W(VEC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .chain_en_in    (chain_en_in),
    .chain_en_out   (chain_en_out),
    .fetch_strobe_n (fetch_strobe_n),
    .io_strobe_n    (io_strobe_n),
    .vector         (vector),
    .irq_n          (irq_n),
    .bus_out        (bus_out),
    .bus_oe         (bus_oe)
);

// File: tb/test_irq_chain_node.sv
module test_irq_chain_node;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             chain_en_in = 1'b1;
    logic             chain_en_out;
    logic             req_pulse = 1'b0;
    logic             fetch_strobe_n = 1'b1;
    logic             io_strobe_n = 1'b1;
    logic             done_pulse = 1'b0;
    logic [VEC_W-1:0] vector = '0;
    logic             irq_n;
    logic [VEC_W-1:0] bus_out;
    logic             bus_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    bit  m_pend = 1'b0;
    bit  m_serv = 1'b0;

    always #5 clk = ~clk;

    irq_chain_node #(.VEC_W(VEC_W)) i_irq_chain_node (
        .clk            (clk),
        .rst            (rst),
        .chain_en_in    (chain_en_in),
        .chain_en_out   (chain_en_out),
        .req_pulse      (req_pulse),
        .fetch_strobe_n (fetch_strobe_n),
        .io_strobe_n    (io_strobe_n),
        .done_pulse     (done_pulse),
        .vector         (vector),
        .irq_n          (irq_n),
        .bus_out        (bus_out),
        .bus_oe         (bus_oe)
    );

    function automatic bit f_ack(input bit a_n, input bit b_n);
        return !a_n && !b_n;
    endfunction

    function automatic bit f_irq_n(input bit p, input bit s, input bit en);
        return !(p && !s && en);
    endfunction

    function automatic bit f_oe(input bit p, input bit s, input bit en, input bit ack);
        return ack && p && !s && en;
    endfunction

    function automatic bit f_en_out(input bit p, input bit s, input bit en, input bit ack);
        return en && !s && !(p && ack);
    endfunction

    task automatic check_bit(input string tag, input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit rq, input bit a_n, input bit b_n,
                        input bit dn, input bit en, input logic [VEC_W-1:0] v,
                        input string tag);
        bit ack;
        bit oe;
        @(negedge clk);
        rst = r; req_pulse = rq; fetch_strobe_n = a_n; io_strobe_n = b_n;
        done_pulse = dn; chain_en_in = en; vector = v;
        #1;
        ack = f_ack(a_n, b_n);
        oe  = f_oe(m_pend, m_serv, en, ack);
        check_bit(tag, "irq_n", irq_n, f_irq_n(m_pend, m_serv, en));
        check_bit(tag, "bus_oe", bus_oe, oe);
        check_bit(tag, "chain_en_out", chain_en_out, f_en_out(m_pend, m_serv, en, ack));
        n_checks++;
        if (bus_out !== (oe ? v : '0)) begin
            n_fails++;
            $display("FAIL %s bus_out: actual=%02h expected=%02h at %0t",
                     tag, bus_out, (oe ? v : 8'h00), $time);
        end
        @(posedge clk);
        if (r) begin
            m_pend = 1'b0; m_serv = 1'b0;
        end else if (oe) begin
            m_serv = 1'b1; m_pend = rq;
        end else if (m_serv && dn && en) begin
            m_serv = 1'b0; m_pend = m_pend | rq;
        end else begin
            m_pend = m_pend | rq;
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, with both enable-in levels
        step(1, 0, 1, 1, 0, 1, 8'h00, "R1");
        step(0, 0, 1, 1, 0, 1, 8'h00, "R1");
        step(0, 0, 1, 1, 0, 0, 8'h00, "R1");
        // R2 / R3: request pulse then pending, masked while enable low
        step(0, 1, 1, 1, 0, 1, 8'h3C, "R2");
        step(0, 0, 1, 1, 0, 1, 8'h3C, "R2");
        step(0, 0, 1, 1, 0, 0, 8'h3C, "R3");
        // R11: single strobes are not acknowledges
        step(0, 0, 0, 1, 0, 1, 8'h3C, "R11");
        step(0, 0, 1, 0, 0, 1, 8'h3C, "R11");
        step(0, 0, 1, 1, 0, 1, 8'h3C, "R11");
        // R5: acknowledge with enable low leaves request pending
        step(0, 0, 0, 0, 0, 0, 8'h3C, "R5");
        step(0, 0, 1, 1, 0, 1, 8'h3C, "R5");
        // R10: second pulse merges; R4: grant drives vector
        step(0, 1, 1, 1, 0, 1, 8'hA5, "R10");
        step(0, 0, 0, 0, 0, 1, 8'hA5, "R4");
        // R6 / R7: under service blocks the chain
        step(0, 0, 1, 1, 0, 1, 8'hA5, "R6");
        step(0, 0, 0, 0, 0, 1, 8'hA5, "R7");
        // R8: release ignored with enable low, observed after enable returns
        step(0, 0, 1, 1, 1, 0, 8'hA5, "R8");
        step(0, 0, 1, 1, 0, 1, 8'hA5, "R8");
        step(0, 0, 1, 1, 1, 1, 8'hA5, "R8");
        step(0, 0, 1, 1, 0, 1, 8'hA5, "R10");
        // R9: request during service resurfaces after release
        step(0, 1, 1, 1, 0, 1, 8'h00, "R2");
        step(0, 0, 0, 0, 0, 1, 8'h5A, "R4");
        step(0, 1, 1, 1, 0, 1, 8'h5A, "R9");
        step(0, 0, 1, 1, 0, 1, 8'h5A, "R9");
        step(0, 0, 1, 1, 1, 1, 8'h5A, "R9");
        step(0, 0, 1, 1, 0, 1, 8'h5A, "R9");
        step(0, 0, 0, 0, 0, 1, 8'hC3, "R4");
        step(1, 0, 1, 1, 0, 1, 8'h00, "R1");
        step(0, 0, 1, 1, 0, 1, 8'h00, "R1");
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit r, rq, a_n, b_n, dn, en;
            r   = ($urandom % 100) == 0;
            rq  = ($urandom % 4) == 0;
            a_n = ($urandom % 3) != 0;
            b_n = ($urandom % 3) != 0;
            dn  = ($urandom % 6) == 0;
            en  = ($urandom % 4) != 0;
            step(r, rq, a_n, b_n, dn, en, VEC_W'($urandom), "R7");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule